// File: doc/BRIEF.md
# No-Wait-State Synchronous Burst SRAM

A clocked static memory whose address, control and write data are all captured on the rising clock edge. A single active-low write strobe chooses read or write on each load cycle. Read data is flow-through: it is driven from the registered address within the cycle that follows the capture edge. Write data and its byte-lane strobes arrive one edge later than the write address. Because of that offset, reads and writes can alternate on every cycle without any idle turnaround.

A load cycle takes a new address. An advance cycle steps an internal 2-bit counter through a four-word group, in either linear or interleaved order. The order is chosen by a static mode pin. Three chip selects qualify each load. A suspend input freezes the whole block. An asynchronous active-low output enable gates the read-data drive. The bidirectional data bus is modelled as separate write-data, read-data and drive-enable ports. Each byte lane is a parameterized number of bits wide (9 by default, so parity bits are stored like data).

Top module: `nowait_burst_sram`

## Requirements
- R1: While reset is asserted and after reset until the first selected read load, `rdata_oe` is 0.
- R2: A selected load with `wr_n`=1 at edge N makes `rdata` equal the word at `addr` during the cycle after edge N, with `rdata_oe`=1 if `out_en_n`=0.
- R3: For a write loaded at edge N, `wdata` and `byte_wr_n` are sampled at edge N+1. Lane g (bits g*LANE_W .. g*LANE_W+LANE_W-1) is written only when `byte_wr_n[g]`=0, and the other lanes keep their old contents.
- R4: A read loaded at the edge right after a write load returns that write's new data, even at the same address; no idle cycle is needed between reads and writes.
- R5: With `interleave`=0, the word used on the k-th advance after a load has low address bits (start + k) mod 4.
- R6: With `interleave`=1, the word used on the k-th advance has low address bits start XOR k.
- R7: A load is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination is a deselect: `rdata_oe`=0, and advance cycles keep the block deselected without moving the burst counter.
- R8: An edge with `suspend`=1 ignores every synchronous input. Address, count, operation and array contents all keep their previous values.
- R9: `out_en_n`=1 forces `rdata_oe` to 0 immediately, without waiting for a clock edge.
- R10: During a write operation `rdata_oe` is 0.
- R11: Advance cycles never change the address bits above the two burst bits. After four advances the 2-bit counter wraps back to the start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| suspend | input | 1 | 1 = ignore this edge entirely and hold all state |
| load_n | input | 1 | 0 = load a new address and operation, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read, sampled on load cycles |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address, low two bits seed the burst |
| interleave | input | 1 | Static burst order: 1 = interleaved, 0 = linear |
| byte_wr_n | input | LANES | Per-lane write strobes, active low, sampled one edge after the write address |
| wdata | input | LANES*LANE_W | Write data, sampled one edge after the write address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | 1 = the block drives the data bus |

## Verification
A wrong base address or burst count shows up at `rdata` in the very cycle after the edge that caused it. The bench checks every word of a burst, so an order or wrap error in the counter is caught within the four-word group. A write committed at the wrong edge, or with the wrong lane mask, stays in the array. It becomes visible at the next read of that address, which the bench issues on the very next cycle. A lost or wrongly set operation flag shows immediately as `rdata_oe` taking the wrong value.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

   // low two address bits of the word used on a given burst step
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       ilv);
      return ilv ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/nwb_burst_ctr.sv
module nwb_burst_ctr #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              load,
   input  logic              op_valid,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] eff_addr
);
   import nwb_pkg::*;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (step_en) begin
         if (load) begin
            base_q <= addr;
            cnt_q  <= '0;
         end else if (op_valid) begin
            cnt_q  <= cnt_q + 2'd1;
         end
      end
   end

   assign eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, interleave)};

endmodule

// File: rtl/nwb_op_reg.sv
module nwb_op_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   input  logic load,
   input  logic selected,
   input  logic wr_n,
   output logic op_valid,
   output logic op_write
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_valid <= 1'b0;
         op_write <= 1'b0;
      end else if (step_en && load) begin
         op_valid <= selected;
         op_write <= selected && !wr_n;
      end
   end

endmodule

// File: rtl/nwb_array.sv
module nwb_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [LANES-1:0]         lane_wr_n,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [LANES*LANE_W-1:0]  rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !lane_wr_n[g])
            store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/nowait_burst_sram.sv
module nowait_burst_sram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    suspend,
   input  logic                    load_n,
   input  logic                    wr_n,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    interleave,
   input  logic [LANES-1:0]        byte_wr_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    out_en_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must leave at least one bit above the burst bits");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be at least 1");
   end

   logic              step_en;
   logic              load;
   logic              selected;
   logic              op_valid;
   logic              op_write;
   logic              commit;
   logic [ADDR_W-1:0] eff_addr;

   assign step_en  = !suspend;
   assign load     = !load_n;
   assign selected = !cs1_n && cs2 && !cs3_n;

   nwb_op_reg u_op (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .load     (load),
      .selected (selected),
      .wr_n     (wr_n),
      .op_valid (op_valid),
      .op_write (op_write)
   );

   nwb_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (step_en),
      .load       (load),
      .op_valid   (op_valid),
      .interleave (interleave),
      .addr       (addr),
      .eff_addr   (eff_addr)
   );

   // the write held since the previous edge lands with this edge's data
   assign commit = step_en && op_valid && op_write;

   nwb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk       (clk),
      .we        (commit),
      .waddr     (eff_addr),
      .lane_wr_n (byte_wr_n),
      .wdata     (wdata),
      .raddr     (eff_addr),
      .rdata     (rdata)
   );

   assign rdata_oe = !out_en_n && op_valid && !op_write;

endmodule

// File: rtl/nwb_chk.sv
module nwb_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              suspend,
   input logic              load_n,
   input logic              wr_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              interleave,
   input logic              out_en_n,
   input logic              rdata_oe,
   input logic              op_valid,
   input logic [ADDR_W-1:0] eff_addr
);

   // R7
   desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && !load_n && (cs1_n || !cs2 || cs3_n)) |=> !op_valid);

   // R7
   desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && load_n && !op_valid) |=>
         ($stable(eff_addr) || interleave != $past(interleave)));

   // R8
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> ($stable(op_valid) &&
                   ($stable(eff_addr) || interleave != $past(interleave))));

   // R9
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rdata_oe);

   // R10
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && !load_n && !wr_n) |=> !rdata_oe);

   // R11
   burst_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && load_n) |=>
         eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2]));

   // R5
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && load_n && op_valid && !interleave) |=>
         (interleave || eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1));

endmodule

bind nowait_burst_sram nwb_chk #(.ADDR_W(ADDR_W)) u_nwb_chk (.*);

// File: tb/test_nowait_burst_sram.sv
`timescale 1ns/1ps
module test_nowait_burst_sram;

   localparam int AW = 6;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN*LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          suspend = 1'b0;
   logic          load_n = 1'b1;
   logic          wr_n = 1'b1;
   logic          cs1_n = 1'b0;
   logic          cs2 = 1'b1;
   logic          cs3_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          interleave = 1'b0;
   logic [LN-1:0] byte_wr_n = '1;
   logic [DW-1:0] wdata = '0;
   logic          out_en_n = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nowait_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_nowait_burst_sram (.*);

   localparam logic [DW-1:0] D10A  = {9'h111, 9'h122, 9'h133, 9'h144};
   localparam logic [DW-1:0] WD10B = {9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD};
   localparam logic [DW-1:0] D10B  = {9'h111, 9'h1BB, 9'h133, 9'h1DD};
   localparam logic [DW-1:0] D11   = {9'h0A1, 9'h0B2, 9'h0C3, 9'h0D4};
   localparam logic [DW-1:0] W0 = 36'h1_0000_0001;
   localparam logic [DW-1:0] W1 = 36'h2_0000_0002;
   localparam logic [DW-1:0] W2 = 36'h3_0000_0003;
   localparam logic [DW-1:0] W3 = 36'h4_0000_0004;

   typedef struct packed {
      logic          ld_n;
      logic          wr_n;
      logic [2:0]    cs;    // {cs1_n, cs2, cs3_n}
      logic [LN-1:0] bw_n;
      logic [AW-1:0] a;
      logic [DW-1:0] wd;
      logic          eoe;
      logic [DW-1:0] ed;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b0, 3'b010, 4'hF,    6'h10, 36'h0, 1'b0, 36'h0}, // write 10
      '{1'b0, 1'b0, 3'b010, 4'h0,    6'h11, D10A,  1'b0, 36'h0}, // write 11, data of 10
      '{1'b0, 1'b1, 3'b010, 4'h0,    6'h10, D11,   1'b1, D10A }, // read 10, data of 11
      '{1'b0, 1'b0, 3'b010, 4'hF,    6'h10, 36'h0, 1'b0, 36'h0}, // write 10 again
      '{1'b0, 1'b1, 3'b010, 4'b1010, 6'h10, WD10B, 1'b1, D10B }, // lanes 0,2 only, read back
      '{1'b0, 1'b1, 3'b110, 4'hF,    6'h00, 36'h0, 1'b0, 36'h0}, // deselect
      '{1'b1, 1'b1, 3'b010, 4'hF,    6'h00, 36'h0, 1'b0, 36'h0}, // advance while deselected
      '{1'b0, 1'b1, 3'b010, 4'hF,    6'h11, 36'h0, 1'b1, D11  }, // read 11
      '{1'b0, 1'b0, 3'b010, 4'hF,    6'h22, 36'h0, 1'b0, 36'h0}, // write burst from 22
      '{1'b1, 1'b1, 3'b010, 4'h0,    6'h00, W0,    1'b0, 36'h0},
      '{1'b1, 1'b1, 3'b010, 4'h0,    6'h00, W1,    1'b0, 36'h0},
      '{1'b1, 1'b1, 3'b010, 4'h0,    6'h00, W2,    1'b0, 36'h0},
      '{1'b0, 1'b1, 3'b010, 4'h0,    6'h23, W3,    1'b1, W1   }, // read burst from 23
      '{1'b1, 1'b1, 3'b010, 4'hF,    6'h00, 36'h0, 1'b1, W2   }, // 20
      '{1'b1, 1'b1, 3'b010, 4'hF,    6'h00, 36'h0, 1'b1, W3   }, // 21
      '{1'b1, 1'b1, 3'b010, 4'hF,    6'h00, 36'h0, 1'b1, W0   }, // 22
      '{1'b1, 1'b1, 3'b010, 4'hF,    6'h00, 36'h0, 1'b1, W1   }  // wrap to 23
   };

   task automatic check(input string req, input logic eoe, input logic [DW-1:0] ed);
      n_chk++;
      if (rdata_oe !== eoe || (eoe && rdata !== ed)) begin
         n_bad++;
         $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", req, rdata_oe, rdata, eoe, ed);
      end
   endtask

   // drive one cycle's inputs, pass the edge, land 2 ns after it
   task automatic cyc(input logic ld, input logic w, input logic [2:0] cs,
                      input logic [LN-1:0] bw, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd);
      load_n = ld; wr_n = w; {cs1_n, cs2, cs3_n} = cs;
      byte_wr_n = bw; addr = a; wdata = wd;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: oe=%0b data=%h expected oe=0 data=0", rdata_oe, rdata);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 during reset", 1'b0, '0);
      rst_n = 1'b1;
      cyc(1'b1, 1'b1, 3'b010, 4'hF, 6'h00, '0);
      check("R1 after reset", 1'b0, '0);

      // table walk: R2 R3 R4 R5 R7 R10 R11
      for (int i = 0; i < NV; i++) begin
         cyc(TBL[i].ld_n, TBL[i].wr_n, TBL[i].cs, TBL[i].bw_n, TBL[i].a, TBL[i].wd);
         check($sformatf("R2/R3/R4/R5/R7/R10/R11 vector %0d", i), TBL[i].eoe, TBL[i].ed);
      end

      // R6 interleaved order from start 3: 23,22,21,20
      interleave = 1'b1;
      cyc(1'b0, 1'b1, 3'b010, 4'hF, 6'h23, '0); check("R6 step0", 1'b1, W1);
      cyc(1'b1, 1'b1, 3'b010, 4'hF, 6'h00, '0); check("R6 step1", 1'b1, W0);
      cyc(1'b1, 1'b1, 3'b010, 4'hF, 6'h00, '0); check("R6 step2", 1'b1, W3);
      cyc(1'b1, 1'b1, 3'b010, 4'hF, 6'h00, '0); check("R6 step3", 1'b1, W2);
      interleave = 1'b0;

      // R8 suspend holds a read and the burst count
      cyc(1'b0, 1'b1, 3'b010, 4'hF, 6'h20, '0); check("R8 setup", 1'b1, W2);
      suspend = 1'b1;
      cyc(1'b0, 1'b0, 3'b010, 4'h0, 6'h11, 36'hF_FFFF_FFFF); check("R8 ignored load", 1'b1, W2);
      cyc(1'b1, 1'b1, 3'b010, 4'h0, 6'h00, 36'hF_FFFF_FFFF); check("R8 ignored advance", 1'b1, W2);
      suspend = 1'b0;
      cyc(1'b1, 1'b1, 3'b010, 4'hF, 6'h00, '0); check("R8 count held", 1'b1, W3);

      // R8 suspend defers a pending write; R3 lane mask
      cyc(1'b0, 1'b0, 3'b010, 4'hF, 6'h30, '0); check("R10 write load", 1'b0, '0);
      cyc(1'b0, 1'b0, 3'b010, 4'h0, 6'h30, 36'h0); check("R10 write again", 1'b0, '0);
      suspend = 1'b1;
      cyc(1'b1, 1'b1, 3'b010, 4'h0, 6'h00, 36'hF_FFFF_FFFF);
      suspend = 1'b0;
      cyc(1'b0, 1'b1, 3'b010, 4'b1110, 6'h30, 36'h5_5555_5555);
      check("R8 R3 deferred write", 1'b1, {27'h0, 9'h155});

      // R9 asynchronous output enable
      out_en_n = 1'b1; #1;
      check("R9 oe released", 1'b0, '0);
      out_en_n = 1'b0; #1;
      check("R9 oe restored", 1'b1, {27'h0, 9'h155});

      // R7 other deselect combinations
      cyc(1'b0, 1'b1, 3'b000, 4'hF, 6'h30, '0); check("R7 cs2 low", 1'b0, '0);
      cyc(1'b0, 1'b1, 3'b011, 4'hF, 6'h30, '0); check("R7 cs3_n high", 1'b0, '0);
      cyc(1'b0, 1'b1, 3'b010, 4'hF, 6'h30, '0); check("R7 reselect", 1'b1, {27'h0, 9'h155});

      // R1 reset mid-read
      rst_n = 1'b0; #1;
      check("R1 reset mid-read", 1'b0, '0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule